// File: doc/BRIEF.md
# Hex Record Stream Loader

This block parses a stream of ASCII characters that carries hexadecimal load records. It turns each record into byte writes on a memory write port. Every record opens with a colon. Hex character pairs then give, in turn, a byte count, a 16-bit load address (high byte first), a record type, the data bytes and a closing check byte. Data bytes are written as they arrive, to the record address and then to each higher address in turn. The record is judged only when its check byte arrives: the modulo-256 sum of every byte in the record, the check byte included, must be zero.

A record of type 01 marks the end of the load. When its checksum is good, the loader raises an end-of-file flag and latches the record's address field as the program start address. Per-record status is reported as one-cycle pulses.

Both streams use valid/ready. A character moves when `char_valid` and `char_ready` are both high at a clock edge. A write moves when `wr_valid` and `wr_ready` are both high. Once `wr_valid` is raised, it and the write address and data stay fixed until `wr_ready` takes the write. While a write waits, `char_ready` is held low, so the loader never holds more than one pending write. At all other times `char_ready` is high and one character can be taken on every cycle.

Top module: `hexrec_loader`

## Requirements
- R1: Characters accepted while no record is open, other than a colon (0x3A), change no output.
- R2: After the colon, the fields are read as hex pairs, high nibble first, in this order: count byte, address high byte, address low byte, type byte, count data bytes, check byte. The digits 0-9, A-F and a-f are all accepted.
- R3: In a type 00 record, data byte i is written to the record address plus i, modulo 2^16. `wr_valid` rises in the cycle after the edge that takes the second character of that byte.
- R4: While `wr_valid` is high and `wr_ready` is low, `char_ready` is low and `wr_addr`/`wr_data` hold their values. In every other cycle `char_ready` is high.
- R5: When the check byte is taken and the record's byte sum is zero modulo 256, `rec_ok` pulses high for exactly one cycle, in the cycle after that edge.
- R6: When the check byte is taken and the sum is not zero, `cksum_err` pulses for one cycle instead. Writes already issued for that record still complete.
- R7: A non-hex character inside an open record, a colon included, pulses `fmt_err` for one cycle and abandons the record. Parsing then waits for the next colon.
- R8: A type 01 record with a good checksum sets `eof` in the same cycle as `rec_ok` and loads `start_addr` with its address field. `eof` stays high until the next colon is taken.
- R9: A record whose type is not 00 issues no writes, but its checksum is still checked and reported.
- R10: After reset, `char_ready` is high and `wr_valid`, `rec_ok`, `cksum_err`, `fmt_err` and `eof` are low, with `start_addr` zero.
- R11: A record with count zero goes from the type byte straight to the check byte and issues no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| char_valid | input | 1 | Character present |
| char_data | input | 8 | ASCII character |
| char_ready | output | 1 | Loader can take a character |
| wr_valid | output | 1 | Write pending |
| wr_ready | input | 1 | Memory takes the pending write |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data byte |
| rec_ok | output | 1 | One-cycle pulse: record passed its checksum |
| cksum_err | output | 1 | One-cycle pulse: record failed its checksum |
| fmt_err | output | 1 | One-cycle pulse: record abandoned on a bad character |
| eof | output | 1 | End-of-file record seen, held until the next colon |
| start_addr | output | 16 | Start address from the end-of-file record |

## Verification
The bench targets the following corner cases, and what a faulty design would show for each:
- A data run that wraps past address FFFF. A design that carried into a seventeenth bit, or reset the address at the wrap, would write to the wrong place.
- A count of zero. A design that did not skip the data phase would treat the check byte as data.
- Lower-case digits. A design that mishandled them would raise format errors.
- A colon arriving mid-record. A design that ignored it, instead of reporting it, would resynchronise to the wrong fields.
- A bad checksum. A design that reported the error too early would pulse before the check byte arrived.
- A design that dropped the writes of a failed record would leave the expected write list unconsumed.
- A memory port that stalls at random. A design that let characters through during a stall would lose bytes or change a pending write.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] REC_MARK  = 8'h3A;
  localparam logic [BYTE_W-1:0] TYPE_DATA = 8'h00;
  localparam logic [BYTE_W-1:0] TYPE_EOF  = 8'h01;

  typedef enum logic [2:0] {
    F_HUNT, F_COUNT, F_ADDR_HI, F_ADDR_LO, F_TYPE, F_DATA, F_CHECK
  } field_e;
endpackage

// File: rtl/hexrec_nibble.sv
module hexrec_nibble #(
  parameter int CHAR_W = 8
) (
  input  logic [CHAR_W-1:0] ch,
  output logic              is_hex,
  output logic [3:0]        nib
);
  logic [CHAR_W-1:0] diff;

  always_comb begin
    is_hex = 1'b1;
    diff   = '0;
    if (ch >= 8'h30 && ch <= 8'h39)      diff = ch - 8'h30;
    else if (ch >= 8'h41 && ch <= 8'h46) diff = ch - 8'h37;
    else if (ch >= 8'h61 && ch <= 8'h66) diff = ch - 8'h57;
    else                                 is_hex = 1'b0;
    nib = diff[3:0];
  end
endmodule

// File: rtl/hexrec_sum.sv
module hexrec_sum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         add,
  input  logic [W-1:0] val,
  output logic [W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (rst || clear) sum <= '0;
    else if (add)     sum <= sum + val;
  end
endmodule

// File: rtl/hexrec_wrport.sv
module hexrec_wrport #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] issue_data,
  input  logic          wr_ready,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (issue) begin
      wr_valid <= 1'b1;
      wr_addr  <= issue_addr;
      wr_data  <= issue_data;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R4
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
  import hexrec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              char_valid,
  input  logic [BYTE_W-1:0] char_data,
  output logic              char_ready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rec_ok,
  output logic              cksum_err,
  output logic              fmt_err,
  output logic              eof,
  output logic [ADDR_W-1:0] start_addr
);
  field_e            state_q;
  logic              phase_q;
  logic [3:0]        hi_q;
  logic [BYTE_W-1:0] cnt_q, rem_q, type_q, sum_q;
  logic [ADDR_W-1:0] addr_q;

  logic              is_hex;
  logic [3:0]        nib;
  logic              take, opening, byte_done, issue;
  logic [BYTE_W-1:0] cur_byte, total;

  hexrec_nibble #(.CHAR_W(BYTE_W)) u_nib (.ch(char_data), .is_hex(is_hex), .nib(nib));

  assign char_ready = !(wr_valid && !wr_ready);
  assign take       = char_valid && char_ready;
  assign opening    = take && (state_q == F_HUNT) && (char_data == REC_MARK);
  assign byte_done  = take && (state_q != F_HUNT) && is_hex && phase_q;
  assign cur_byte   = {hi_q, nib};
  assign total      = sum_q + cur_byte;
  assign issue      = byte_done && (state_q == F_DATA) && (type_q == TYPE_DATA);

  hexrec_sum #(.W(BYTE_W)) u_sum (
    .clk(clk), .rst(rst), .clear(opening),
    .add(byte_done && (state_q != F_CHECK)), .val(cur_byte), .sum(sum_q)
  );

  hexrec_wrport #(.AW(ADDR_W), .DW(BYTE_W)) u_wr (
    .clk(clk), .rst(rst), .issue(issue), .issue_addr(addr_q), .issue_data(cur_byte),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= F_HUNT;
      phase_q    <= 1'b0;
      hi_q       <= '0;
      cnt_q      <= '0;
      rem_q      <= '0;
      type_q     <= '0;
      addr_q     <= '0;
      rec_ok     <= 1'b0;
      cksum_err  <= 1'b0;
      fmt_err    <= 1'b0;
      eof        <= 1'b0;
      start_addr <= '0;
    end else begin
      rec_ok    <= 1'b0;
      cksum_err <= 1'b0;
      fmt_err   <= 1'b0;
      if (take) begin
        if (state_q == F_HUNT) begin
          if (opening) begin
            state_q <= F_COUNT;
            phase_q <= 1'b0;
            eof     <= 1'b0;
          end
        end else if (!is_hex) begin
          fmt_err <= 1'b1;
          state_q <= F_HUNT;
          phase_q <= 1'b0;
        end else if (!phase_q) begin
          hi_q    <= nib;
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          case (state_q)
            F_COUNT: begin
              cnt_q   <= cur_byte;
              rem_q   <= cur_byte;
              state_q <= F_ADDR_HI;
            end
            F_ADDR_HI: begin
              addr_q  <= {cur_byte, addr_q[BYTE_W-1:0]};
              state_q <= F_ADDR_LO;
            end
            F_ADDR_LO: begin
              addr_q  <= {addr_q[ADDR_W-1:BYTE_W], cur_byte};
              state_q <= F_TYPE;
            end
            F_TYPE: begin
              type_q  <= cur_byte;
              state_q <= (cnt_q == '0) ? F_CHECK : F_DATA;
            end
            F_DATA: begin
              if (type_q == TYPE_DATA) addr_q <= addr_q + 1'b1;
              rem_q <= rem_q - 1'b1;
              if (rem_q == 8'd1) state_q <= F_CHECK;
            end
            F_CHECK: begin
              state_q <= F_HUNT;
              if (total == '0) begin
                rec_ok <= 1'b1;
                if (type_q == TYPE_EOF) begin
                  eof        <= 1'b1;
                  start_addr <= addr_q;
                end
              end else begin
                cksum_err <= 1'b1;
              end
            end
            default: state_q <= F_HUNT;
          endcase
        end
      end
    end
  end

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({rec_ok, cksum_err, fmt_err}) <= 1); // R5
  AST_VERDICT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (rec_ok || cksum_err) |-> (state_q == F_HUNT)); // R6
  AST_FMT_ABANDON: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> (state_q == F_HUNT)); // R7
  AST_EOF_WITH_OK: assert property (@(posedge clk) disable iff (rst)
    $rose(eof) |-> rec_ok); // R8
  AST_WRITE_TYPE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> ($past(type_q) == TYPE_DATA)); // R9
endmodule

// File: tb/hexrec_loader_tb.sv
module hexrec_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic char_valid = 1'b0, wr_ready = 1'b1;
  logic [7:0] char_data = 8'h00;
  logic char_ready, wr_valid, rec_ok, cksum_err, fmt_err, eof;
  logic [15:0] wr_addr, start_addr;
  logic [7:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  hexrec_loader dut_i (
    .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
    .char_ready(char_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rec_ok(rec_ok), .cksum_err(cksum_err),
    .fmt_err(fmt_err), .eof(eof), .start_addr(start_addr)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit started = 0, stall_mode = 0, took = 0;
  int n_wr = 0, n_ok = 0, n_ce = 0, n_fe = 0;
  int exp_wr[$];
  int payload[$];

  // reference model state
  int ms = 0, ph = 0, mhi = 0, mcnt = 0, mrem = 0, mtype = 0, maddr = 0, msum = 0;
  bit m_wv = 0, m_ok = 0, m_ce = 0, m_fe = 0, m_eof = 0;
  int m_wa = 0, m_wd = 0, m_start = 0;

  function automatic int hexval(input int c);
    if (c >= 48 && c <= 57) return c - 48;
    if (c >= 65 && c <= 70) return c - 55;
    if (c >= 97 && c <= 102) return c - 87;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; ph = 0; maddr = 0; msum = 0; mtype = 0;
      m_wv = 0; m_ok = 0; m_ce = 0; m_fe = 0; m_eof = 0; m_wa = 0; m_wd = 0; m_start = 0;
      took = 0; started = 1;
    end else begin
      automatic int c = char_data;
      automatic int h = hexval(c);
      took = char_valid && !(m_wv && !wr_ready);
      m_ok = 0; m_ce = 0; m_fe = 0;
      if (m_wv && wr_ready) m_wv = 0;
      if (took) begin
        if (ms == 0) begin
          if (c == 58) begin ms = 1; ph = 0; m_eof = 0; msum = 0; end
        end else if (h < 0) begin
          m_fe = 1; ms = 0; ph = 0;
        end else if (ph == 0) begin
          mhi = h; ph = 1;
        end else begin
          automatic int b = mhi * 16 + h;
          ph = 0;
          if (ms != 6) msum = (msum + b) % 256;
          case (ms)
            1: begin mcnt = b; mrem = b; ms = 2; end
            2: begin maddr = (maddr % 256) + b * 256; ms = 3; end
            3: begin maddr = (maddr / 256) * 256 + b; ms = 4; end
            4: begin mtype = b; ms = (mcnt == 0) ? 6 : 5; end
            5: begin
              if (mtype == 0) begin
                m_wv = 1; m_wa = maddr; m_wd = b; maddr = (maddr + 1) % 65536;
              end
              mrem--;
              if (mrem == 0) ms = 6;
            end
            default: begin
              ms = 0;
              if ((msum + b) % 256 == 0) begin
                m_ok = 1;
                if (mtype == 1) begin m_eof = 1; m_start = maddr; end
              end else m_ce = 1;
            end
          endcase
        end
      end
    end
  end

  // port-level observation of handshakes and pulses (pre-update values)
  always @(posedge clk) if (!rst && started) begin
    if (wr_valid && wr_ready) begin
      n_wr++;
      if (exp_wr.size() == 0) chk(0, "R3 unexpected write", wr_addr, 0);
      else begin
        automatic int e = exp_wr.pop_front();
        chk({wr_addr, wr_data} == e[23:0], "R3 write addr/data", {wr_addr, wr_data}, e);
      end
    end
    if (rec_ok) n_ok++;
    if (cksum_err) n_ce++;
    if (fmt_err) n_fe++;
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) if (started && !rst) begin
    chk(char_ready == !(m_wv && !wr_ready), "R4 char_ready", char_ready, !(m_wv && !wr_ready));
    chk(wr_valid == m_wv, "R3 wr_valid", wr_valid, m_wv);
    if (m_wv) chk(wr_addr == m_wa[15:0] && wr_data == m_wd[7:0], "R3 wr_addr/wr_data",
                  {wr_addr, wr_data}, {m_wa[15:0], m_wd[7:0]});
    chk(rec_ok == m_ok, "R5 rec_ok", rec_ok, m_ok);
    chk(cksum_err == m_ce, "R6 cksum_err", cksum_err, m_ce);
    chk(fmt_err == m_fe, "R7 fmt_err", fmt_err, m_fe);
    chk(eof == m_eof && start_addr == m_start[15:0], "R8 eof/start_addr",
        {eof, start_addr}, {m_eof, m_start[15:0]});
  end

  always @(negedge clk) begin
    #1;
    cyc++;
    wr_ready <= stall_mode ? ((cyc % 3) == 0) : 1'b1;
  end

  task automatic send(input int c);
    @(negedge clk); #2;
    char_valid = 1'b1; char_data = c[7:0];
    do begin @(posedge clk); #1; end while (!took);
    char_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int hexch(input int v, input bit lower);
    if (v < 10) return 48 + v;
    return (lower ? 87 : 55) + v;
  endfunction

  task automatic send_byte(input int b, input bit lower);
    send(hexch(b / 16, lower));
    send(hexch(b % 16, lower));
  endtask

  task automatic send_rec(input int addr, input int typ, input bit lower, input bit corrupt);
    automatic int s = payload.size() + addr / 256 + addr % 256 + typ;
    foreach (payload[i]) s += payload[i];
    send(58);
    send_byte(payload.size(), lower);
    send_byte(addr / 256, lower);
    send_byte(addr % 256, lower);
    send_byte(typ, lower);
    foreach (payload[i]) begin
      if (typ == 0) exp_wr.push_back(((addr + i) % 65536) * 256 + payload[i]);
      send_byte(payload[i], lower);
    end
    send_byte(((256 - (s % 256)) + (corrupt ? 1 : 0)) % 256, lower);
    idle(4);
  endtask

  initial begin
    automatic int b_wr, b_ok, b_ce, b_fe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(char_ready && !wr_valid && !rec_ok && !cksum_err && !fmt_err && !eof && start_addr == 0,
        "R10 reset state", {char_ready, wr_valid, eof}, 3'b100);

    b_wr = n_wr; b_ok = n_ok; b_fe = n_fe;
    send(120); send(48); send(65); send(10);
    idle(3);
    chk(n_wr == b_wr && n_ok == b_ok && n_fe == b_fe, "R1 noise before colon", n_wr, b_wr);

    payload = '{8'h11, 8'hA5, 8'h3C};
    b_ok = n_ok;
    send_rec(16'h1234, 0, 0, 0);
    chk(n_ok == b_ok + 1 && exp_wr.size() == 0, "R2 upper-case data record", n_ok, b_ok + 1);

    payload = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
    b_ok = n_ok;
    send_rec(16'hFFFE, 0, 1, 0);
    chk(n_ok == b_ok + 1 && exp_wr.size() == 0, "R2 lower-case record with address wrap",
        n_ok, b_ok + 1);

    payload = '{8'h01, 8'h02};
    b_ce = n_ce; b_wr = n_wr;
    send_rec(16'h0200, 0, 0, 1);
    chk(n_ce == b_ce + 1 && n_wr == b_wr + 2, "R6 bad checksum keeps writes", n_wr, b_wr + 2);

    payload = '{8'h77, 8'h88};
    b_ok = n_ok; b_wr = n_wr;
    send_rec(16'h0300, 2, 0, 0);
    chk(n_ok == b_ok + 1 && n_wr == b_wr, "R9 other type no writes", n_wr, b_wr);

    payload = '{};
    b_ok = n_ok; b_wr = n_wr;
    send_rec(16'h0400, 0, 0, 0);
    chk(n_ok == b_ok + 1 && n_wr == b_wr, "R11 zero count record", n_ok, b_ok + 1);

    b_fe = n_fe; b_wr = n_wr;
    send(58); send(48); send(71); idle(3);
    chk(n_fe == b_fe + 1 && n_wr == b_wr, "R7 bad digit aborts", n_fe, b_fe + 1);
    send(58); send(48); send(49); send(49); send(58); idle(3);
    chk(n_fe == b_fe + 2, "R7 colon inside record aborts", n_fe, b_fe + 2);

    stall_mode = 1;
    payload = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50};
    b_ok = n_ok;
    send_rec(16'h8000, 0, 0, 0);
    idle(6);
    chk(n_ok == b_ok + 1 && exp_wr.size() == 0, "R4 stalled write port", exp_wr.size(), 0);
    stall_mode = 0;

    payload = '{};
    send_rec(16'h4000, 1, 0, 0);
    chk(eof && start_addr == 16'h4000, "R8 end-of-file start address", start_addr, 16'h4000);
    send(58); idle(2);
    chk(!eof, "R8 eof clears on next colon", eof, 0);
    send_byte(0, 0); send(33); idle(3);

    idle(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule